// File: doc/BRIEF.md
# Interruptible Multi-Register Transfer Sequencer

This block turns one multi-register load or store into a string of single-word bus transfers, taken one register at a time from a register list bitmask. The bus has a single outstanding transfer. A request is held, with a stable address, until the bus answers with ready. Loads write each returned word into the register file. Stores read each register from the register file and drive it as write data.

An interrupt-pending input is sampled only at a transfer boundary, that is, in the cycle in which a word completes. If more registers remain, the sequencer stops there. It pulses a suspended flag and exports a continuation index, which is the number of the next register still to move. Starting again with that index as the resume value picks up at that register. The resume uses the same base address, and registers already moved are not repeated. In paired mode the operation moves two words and is all-or-nothing. An interrupt after the first word abandons it with a continuation index of zero, so the whole pair is redone from its first word. The same behaviour serves integer and floating-point register lists alike.

Top module: `ms_seq`

## Requirements
- R1: Once a bus request is raised it stays raised, with `bus_addr` and `bus_we` unchanged, until the cycle in which `bus_ready` is high. The word completes at that clock edge.
- R2: Registers are transferred in ascending register number. A register whose bit is set in `reg_list` is moved at address `base_addr + 4*k`, where k is the number of set list bits below its own bit position.
- R3: For a load (`is_store`=0), the completing cycle drives `rf_we`=1, `rf_waddr` = the register number and `rf_wdata` = `bus_rdata`. For a store (`is_store`=1), `rf_raddr` names the register, `bus_wdata` carries `rf_rdata`, `bus_we`=1 and `rf_we` stays 0.
- R4: If `irq_pending` is high when a word completes and more words of the operation remain, no further request is raised. `suspended` pulses in the next cycle, with `cont_idx` holding the number of the next untransferred register, which is never 0.
- R5: A start with a nonzero `resume_idx` moves only the listed registers numbered at or above `resume_idx`, at the addresses given by R2 for the full list. A value of 0 starts from the beginning.
- R6: With `pair_mode`=1, only the two lowest-numbered listed registers are moved and `resume_idx` is ignored. An interrupt after the first word gives `suspended` with `cont_idx`=0 and no `done`.
- R7: `done` pulses for one cycle, in the cycle after the final word completes. `done` and `suspended` are never high together.
- R8: A `start` that arrives while an operation is active is ignored and does not change the operation in progress.
- R9: A start with no listed register at or above the resume point raises no bus request and pulses `done` in the next cycle.
- R10: An interrupt that is pending when the last word of the operation completes has no effect. The operation ends with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| reg_list | input | 16 | Register list bitmask, bit n = register n |
| base_addr | input | 32 | Byte address of the lowest listed register |
| is_store | input | 1 | 1 = store to memory, 0 = load from memory |
| pair_mode | input | 1 | 1 = two-word all-or-nothing operation |
| resume_idx | input | 4 | Continuation index to resume from, 0 = fresh |
| irq_pending | input | 1 | Interrupt waiting to be taken |
| bus_req | output | 1 | Bus transfer request |
| bus_addr | output | 32 | Transfer address |
| bus_we | output | 1 | Transfer is a write |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Transfer completes at this edge |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| rf_raddr | output | 4 | Register file read address (stores) |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 32 | Register file write data |
| done | output | 1 | Operation finished (one-cycle pulse) |
| suspended | output | 1 | Operation stopped early (one-cycle pulse) |
| cont_idx | output | 4 | Continuation index, valid from the suspended pulse until the next start |

## Verification
The first request rises one cycle after the edge that takes `start`. The register file write and store data are combinational in the cycle that `bus_ready` is high. `done` or `suspended` follows one cycle after the last completing edge, or one cycle after the start edge when no register remains. The bench's bus model decides `bus_ready` on the falling edge and samples the write port and bus outputs just after that decision. The bench records the cycle number of each completion and of the end pulse, and requires the end pulse exactly one cycle after the final completion, or after the start for an empty operation. Bus latencies of zero to three cycles check that the address stays held while the request waits.

// File: rtl/ms_pkg.sv
package ms_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_XFER = 1'b1
  } sq_state_t;
endpackage

// File: rtl/ms_pick.sv
module ms_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] list,
  input  logic [IW:0]     from,
  output logic            found,
  output logic [IW-1:0]   idx
);
  logic [NREG-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_cand
      assign cand[g] = list[g] && ((IW+1)'(g) >= from);
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ms_addr.sv
module ms_addr #(
  parameter int NREG = 16,
  parameter int AW = 32,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] list,
  input  logic [IW-1:0]   reg_idx,
  input  logic [AW-1:0]   base,
  output logic [AW-1:0]   addr
);
  function automatic logic [IW:0] count_below(input logic [NREG-1:0] l,
                                              input logic [IW-1:0] r);
    logic [IW:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) begin
      if (l[i] && (IW'(i) < r)) c = c + 1'b1;
    end
    return c;
  endfunction

  assign addr = base + AW'(count_below(list, reg_idx)) * AW'(WORD_BYTES);
endmodule

// File: rtl/ms_seq.sv
module ms_seq #(
  parameter int NREG = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NREG-1:0] reg_list,
  input  logic [AW-1:0]   base_addr,
  input  logic            is_store,
  input  logic            pair_mode,
  input  logic [IW-1:0]   resume_idx,
  input  logic            irq_pending,
  output logic            bus_req,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_we,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ready,
  input  logic [DW-1:0]   bus_rdata,
  output logic [IW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            done,
  output logic            suspended,
  output logic [IW-1:0]   cont_idx
);
  import ms_pkg::*;

  sq_state_t       st;
  logic [NREG-1:0] list_q;
  logic [AW-1:0]   base_q;
  logic            store_q, pair_q, second_q;
  logic [IW-1:0]   cur_q;
  logic            done_q, susp_q;
  logic [IW-1:0]   cont_q;

  // named internal events
  logic          accept, xfer_fire, more_left, stop_irq;
  logic          first_found, next_found;
  logic [IW-1:0] first_idx, next_idx;
  logic [IW:0]   first_from, next_from;

  assign first_from = pair_mode ? '0 : {1'b0, resume_idx};
  assign next_from  = {1'b0, cur_q} + 1'b1;

  ms_pick #(.NREG(NREG)) u_first (
    .list(reg_list), .from(first_from), .found(first_found), .idx(first_idx)
  );

  ms_pick #(.NREG(NREG)) u_next (
    .list(list_q), .from(next_from), .found(next_found), .idx(next_idx)
  );

  ms_addr #(.NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .list(list_q), .reg_idx(cur_q), .base(base_q), .addr(bus_addr)
  );

  assign accept    = (st == SQ_IDLE) && start;
  assign xfer_fire = (st == SQ_XFER) && bus_ready;
  assign more_left = next_found && !(pair_q && second_q);
  assign stop_irq  = xfer_fire && more_left && irq_pending;

  assign bus_req   = (st == SQ_XFER);
  assign bus_we    = store_q;
  assign bus_wdata = rf_rdata;
  assign rf_raddr  = cur_q;
  assign rf_we     = xfer_fire && !store_q;
  assign rf_waddr  = cur_q;
  assign rf_wdata  = bus_rdata;

  assign done      = done_q;
  assign suspended = susp_q;
  assign cont_idx  = cont_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      list_q   <= '0;
      base_q   <= '0;
      store_q  <= 1'b0;
      pair_q   <= 1'b0;
      second_q <= 1'b0;
      cur_q    <= '0;
      done_q   <= 1'b0;
      susp_q   <= 1'b0;
      cont_q   <= '0;
    end else begin
      done_q <= 1'b0;
      susp_q <= 1'b0;
      if (accept) begin
        list_q   <= reg_list;
        base_q   <= base_addr;
        store_q  <= is_store;
        pair_q   <= pair_mode;
        second_q <= 1'b0;
        cur_q    <= first_idx;
        cont_q   <= '0;
        if (first_found) st <= SQ_XFER;
        else             done_q <= 1'b1;
      end else if (xfer_fire) begin
        if (!more_left) begin
          st     <= SQ_IDLE;
          done_q <= 1'b1;
        end else if (irq_pending) begin
          st     <= SQ_IDLE;
          susp_q <= 1'b1;
          cont_q <= pair_q ? '0 : next_idx;
        end else begin
          cur_q    <= next_idx;
          second_q <= 1'b1;
        end
      end
    end
  end

  // R1: an open transfer is never cut or altered
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  // R4: interrupt at a boundary with work left stops the sequence
  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |=> suspended && !bus_req);

  // R4: a resumable stop never exports the fresh-start index
  a_r4_cont_nz: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !pair_q |-> cont_idx != '0);

  // R6: an abandoned pair leaves no continuation
  a_r6_pair_cont: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && pair_q |-> cont_idx == '0 && !done);

  // R7: end pulses are exclusive
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && suspended));

  // R10: the final word always ends in done
  a_r10_last: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire && !more_left |=> done && !suspended);

  // R8: start while busy leaves the captured operation alone
  a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && start |=> $stable(list_q) && $stable(base_q) && $stable(store_q));
endmodule

// File: tb/sim_ms_seq.sv
module sim_ms_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [31:0] base_addr = '0;
  logic        is_store = 1'b0;
  logic        pair_mode = 1'b0;
  logic [3:0]  resume_idx = '0;
  logic        irq_pending = 1'b0;
  logic        bus_req, bus_we, bus_ready = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, rf_rdata, rf_wdata;
  logic [3:0]  rf_raddr, rf_waddr, cont_idx;
  logic        rf_we, done, suspended;

  always #2 clk = ~clk;

  assign bus_rdata = 32'hA500_0000 ^ bus_addr;
  assign rf_rdata  = 32'h5A00_0000 | {28'h0, rf_raddr};

  ms_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
    .base_addr(base_addr), .is_store(is_store), .pair_mode(pair_mode),
    .resume_idx(resume_idx), .irq_pending(irq_pending), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .done(done), .suspended(suspended), .cont_idx(cont_idx)
  );

  int total = 0, bad = 0, cyc = 0;
  int mem_lat = 0, irq_at = 0, n_log = 0, wcnt = 0, last_cyc = 0;
  logic [31:0] hold_addr;
  logic [31:0] lg_addr [0:31];
  logic [31:0] lg_data [0:31];
  logic [3:0]  lg_rfa  [0:31];
  logic        lg_we   [0:31];
  logic        lg_rfwe [0:31];
  logic        lg_stab [0:31];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // bus model: decides ready on the falling edge, logs the completing word
  always @(negedge clk) begin
    if (bus_req) begin
      if (wcnt == 0) hold_addr = bus_addr;
      if (wcnt >= mem_lat) begin
        bus_ready   = 1'b1;
        irq_pending = (irq_at > 0) && (n_log + 1 == irq_at);
        #1;
        if (n_log < 32) begin
          lg_addr[n_log] = bus_addr;
          lg_we[n_log]   = bus_we;
          lg_data[n_log] = bus_we ? bus_wdata : rf_wdata;
          lg_rfa[n_log]  = rf_waddr;
          lg_rfwe[n_log] = rf_we;
          lg_stab[n_log] = (hold_addr == bus_addr);
        end
        n_log++;
        last_cyc = cyc;
        wcnt = 0;
      end else begin
        bus_ready = 1'b0;
        irq_pending = 1'b0;
        wcnt++;
      end
    end else begin
      bus_ready = 1'b0;
      irq_pending = 1'b0;
      wcnt = 0;
    end
  end

  task automatic run_op(input string nm, input logic [15:0] l, input logic [31:0] b,
                        input bit st, input bit pr, input logic [3:0] res,
                        input int irq_after, input int lat, input bit poke,
                        output logic [3:0] cont_out);
    int exp_regs [0:15];
    int tot = 0, perf, t0, endc = -1, k;
    bit got_done = 0, got_susp = 0, exp_susp;
    logic [3:0] exp_cont;
    for (int r = (pr ? 0 : int'(res)); r < 16; r++)
      if (l[r] && !(pr && tot == 2)) begin exp_regs[tot] = r; tot++; end
    exp_susp = (irq_after > 0) && (irq_after < tot);
    perf = exp_susp ? irq_after : tot;
    exp_cont = (exp_susp && !pr) ? 4'(exp_regs[irq_after]) : 4'd0;
    mem_lat = lat; irq_at = irq_after; n_log = 0;
    @(negedge clk);
    start = 1'b1; reg_list = l; base_addr = b; is_store = st;
    pair_mode = pr; resume_idx = res; t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (k < 300) begin
      if (done || suspended) begin
        got_done = done; got_susp = suspended; endc = cyc;
        cont_out = cont_idx;
        break;
      end
      @(negedge clk);
      if (poke && k == 1) begin
        start = 1'b1; reg_list = 16'hFFFF; base_addr = 32'h0; is_store = ~st;
      end else if (poke && k == 2) begin
        start = 1'b0;
      end
      k++;
    end
    start = 1'b0;
    // R7 end kind, exclusive pulse, R4/R6/R10 outcome
    chk(got_done != exp_susp && got_susp == exp_susp && !(got_done && got_susp),
        {nm, " R7/R10 end kind"}, {got_done, got_susp}, {!exp_susp, exp_susp});
    chk(n_log == perf, {nm, " R4/R9 word count"}, n_log, perf);
    if (exp_susp)
      chk(cont_out == exp_cont, {nm, " R4/R6 cont_idx"}, cont_out, exp_cont);
    if (perf > 0)
      chk(endc == last_cyc + 1, {nm, " R7 end latency"}, endc, last_cyc + 1);
    else
      chk(endc == t0 + 1, {nm, " R9 empty latency"}, endc, t0 + 1);
    for (int i = 0; i < perf && i < n_log && i < 32; i++) begin
      int cnt = 0;
      logic [31:0] ea, ed;
      for (int j = 0; j < exp_regs[i]; j++) if (l[j]) cnt++;
      ea = b + 32'(cnt * 4);
      ed = st ? (32'h5A00_0000 | 32'(exp_regs[i])) : (32'hA500_0000 ^ ea);
      chk(lg_addr[i] == ea, {nm, " R2/R5 address"}, lg_addr[i], ea);
      chk(lg_stab[i], {nm, " R1 address held"}, lg_addr[i], ea);
      chk(lg_we[i] == st && lg_rfwe[i] == !st, {nm, " R3 direction"},
          {lg_we[i], lg_rfwe[i]}, {st, !st});
      chk(lg_data[i] == ed, {nm, " R3 data"}, lg_data[i], ed);
      if (!st)
        chk(lg_rfa[i] == 4'(exp_regs[i]), {nm, " R3 rf_waddr"}, lg_rfa[i], exp_regs[i]);
    end
    @(negedge clk);
    chk(!done && !suspended && !bus_req, {nm, " R7 single pulse"},
        {done, suspended, bus_req}, 0);
  endtask

  task automatic t_reset();
    chk(!bus_req && !done && !suspended && !rf_we && cont_idx == 0,
        "reset R7 outputs idle", {bus_req, done, suspended, rf_we, cont_idx}, 0);
  endtask

  task automatic t_basic();
    logic [3:0] c;
    run_op("load R2 R3", 16'h00A5, 32'h1000, 0, 0, 0, 0, 0, 0, c);
    run_op("store R3", 16'h8101, 32'h2000, 1, 0, 0, 0, 2, 0, c);
  endtask

  task automatic t_suspend_resume();
    logic [3:0] c;
    run_op("load R4 stop", 16'h0F0F, 32'h3000, 0, 0, 0, 3, 1, 0, c);
    run_op("load R5 resume", 16'h0F0F, 32'h3000, 0, 0, c, 0, 1, 0, c);
    run_op("store R4 stop", 16'hC3C0, 32'h4000, 1, 0, 0, 1, 3, 0, c);
    run_op("store R5 resume", 16'hC3C0, 32'h4000, 1, 0, c, 0, 0, 0, c);
  endtask

  task automatic t_pair();
    logic [3:0] c;
    run_op("pair R6 abandon", 16'h0030, 32'h5000, 0, 1, 0, 1, 1, 0, c);
    run_op("pair R6 redo", 16'h0030, 32'h5000, 0, 1, 4'd7, 0, 0, 0, c);
    run_op("pair R6 limit", 16'h0E01, 32'h5100, 1, 1, 0, 0, 1, 0, c);
  endtask

  task automatic t_edges();
    logic [3:0] c;
    run_op("last R10", 16'h0003, 32'h6000, 0, 0, 0, 2, 1, 0, c);
    run_op("empty R9", 16'h0000, 32'h7000, 0, 0, 0, 0, 0, 0, c);
    run_op("beyond R9", 16'h000F, 32'h7000, 0, 0, 4'd8, 0, 0, 0, c);
    run_op("busy R8", 16'h1111, 32'h8000, 0, 0, 0, 0, 2, 1, c);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_suspend_resume();
    t_pair();
    t_edges();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule